// File: doc/BRIEF.md
# 32-Pin General-Purpose I/O Port with Interrupt Detection

This block is one 32-pin general-purpose I/O port controlled through a simple memory-mapped register bus. Each bus access completes in a single cycle. Writes take effect at the clock edge. Reads are returned combinationally in the cycle the address is presented. Software picks a direction per pin and drives output levels. Output bits can be written as a whole word, or changed atomically by writing ones into a set word or a clear word, so no read-modify-write is needed.

Every pin input passes through a two-flop synchroniser. The synchronised value feeds the input-data word and a per-pin interrupt detector. Each pin can raise a pending interrupt on a rising edge, a falling edge, either edge, a high level or a low level. The sense is chosen by three per-pin control bits: a level-mode bit, an any-edge bit and an invert bit.

A pending bit counts in the status word only while its enable bit is set. It is acknowledged by writing a one to the interrupt-clear word. Unmasked status bits are ORed into one interrupt line for the system interrupt controller. Two pull-configuration words are plain storage for the pad logic outside this block.

Top module: `gpio_irq_port`

## Requirements
- R1: The byte offsets decoded on the 8-bit address are fixed, because software depends on them.
  - Offsets that read back the last value written: output word 0x00, direction 0x08, pull-on 0x18, pull-select 0x1C, interrupt enable 0x20, mask 0x2C, level-mode 0x34, any-edge 0x38, invert 0x3C.
  - Read-only offsets: input word 0x04 and status 0x24.
  - Write-only offsets, which read as zero: set 0x10, clear 0x14 and interrupt clear 0x30.
  - After reset, every register reads zero.
- R2: Bit n of every register belongs to pin n. `pin_oe[n]` equals direction bit n, where 1 means output and 0 means input. `pin_out` always equals the output word.
- R3: Writing to the set word (0x10) sets every output bit where the written data has a one. Writing to the clear word (0x14) clears every output bit where the written data has a one. Zero bits leave those outputs unchanged.
- R4: The input word (0x04) returns `pin_in` as sampled by two flops, so a pin change is visible after the second rising clock edge.
- R5: When a pin's level-mode bit is 0, the pin is edge sensitive.
  - With the any-edge bit at 1, either edge latches the pending bit.
  - With the any-edge bit at 0, invert 0 selects the rising edge and invert 1 selects the falling edge.
  - A latched edge stays pending until it is cleared.
- R6: When a pin's level-mode bit is 1, the pin is level sensitive: invert 0 means active high and invert 1 means active low. While the level stays active, the pending bit is set again one cycle after a clear.
- R7: Writing a one to bit n of the interrupt-clear word (0x30) clears pending bit n. If a new event on that pin arrives in the same cycle as the clear, the event wins and the bit stays pending.
- R8: The status word (0x24) reads the pending bits ANDed with the enable word. A pin whose enable bit is 0 latches no event.
- R9: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 hides that pin from `irq_o` but not from status.
- R10: The pull-on and pull-select words are storage only and do not change `pin_out`, `pin_oe` or the interrupt logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| irq_o | output | 1 | Combined unmasked interrupt request |

## Verification
The hardest case to reach from the ports is an interrupt-clear write that lands in exactly the cycle in which a synchronised edge arrives at the detector. The bench counts the two synchroniser flops, toggles a pin and issues the clear write so that it spans the third rising edge after the toggle. It then checks that the pending bit survived. Level-sensitive re-assertion after a clear, and stale pending bits hidden behind a cleared enable, are reached by reconfiguring the sense bits while the pins are held steady. A seeded random mix of pin toggles, clears and configuration writes then runs against a bench model of the pending word.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned GPIO_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IN    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PON   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PSEL  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_ICLR  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_LMODE = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_ANYE  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_INV   = 8'h3C;

    // Per-pin interrupt sense selection, one bit per pin in each field
    typedef struct packed {
        logic [GPIO_W-1:0] lvl_mode;  // 1 = level sensitive
        logic [GPIO_W-1:0] any_edge;  // 1 = both edges (edge mode only)
        logic [GPIO_W-1:0] invert;    // 1 = falling edge / active low
    } sense_cfg_t;

    // Event for one pin, given its current and previous synchronised value
    function automatic logic pin_event(input logic cur, input logic prev,
                                       input logic lvl, input logic any,
                                       input logic inv);
        logic ev;
        if (lvl)
            ev = cur ^ inv;
        else if (any)
            ev = cur ^ prev;
        else if (inv)
            ev = prev & ~cur;
        else
            ev = cur & ~prev;
        return ev;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W  = GPIO_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  pin_sync,
    input  logic [W-1:0]  status,
    output logic [W-1:0]  out_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  ien_q,
    output logic [W-1:0]  mask_q,
    output sense_cfg_t    cfg_q,
    output logic [W-1:0]  ack_bits
);
    logic [W-1:0] pon_q;
    logic [W-1:0] psel_q;
    logic         wr_en;

    assign wr_en = sel & wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            pon_q  <= '0;
            psel_q <= '0;
            ien_q  <= '0;
            mask_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_OUT:   out_q <= wdata;
                OFS_SET:   out_q <= out_q | wdata;
                OFS_CLR:   out_q <= out_q & ~wdata;
                OFS_DIR:   dir_q <= wdata;
                OFS_PON:   pon_q <= wdata;
                OFS_PSEL:  psel_q <= wdata;
                OFS_IEN:   ien_q <= wdata;
                OFS_MASK:  mask_q <= wdata;
                OFS_LMODE: cfg_q.lvl_mode <= wdata;
                OFS_ANYE:  cfg_q.any_edge <= wdata;
                OFS_INV:   cfg_q.invert <= wdata;
                default: ;
            endcase
        end
    end

    assign ack_bits = (wr_en && addr == OFS_ICLR) ? wdata : '0;

    always_comb begin
        case (addr)
            OFS_OUT:   rdata = out_q;
            OFS_IN:    rdata = pin_sync;
            OFS_DIR:   rdata = dir_q;
            OFS_PON:   rdata = pon_q;
            OFS_PSEL:  rdata = psel_q;
            OFS_IEN:   rdata = ien_q;
            OFS_STAT:  rdata = status;
            OFS_MASK:  rdata = mask_q;
            OFS_LMODE: rdata = cfg_q.lvl_mode;
            OFS_ANYE:  rdata = cfg_q.any_edge;
            OFS_INV:   rdata = cfg_q.invert;
            default:   rdata = '0;
        endcase
    end

    AST_SET_ONES: assert property (@(posedge clk) disable iff (rst) (wr_en && addr == OFS_SET) |=> ((out_q & $past(wdata)) == $past(wdata))); // R3
    AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (rst) (wr_en && addr == OFS_CLR) |=> ((out_q & $past(wdata)) == '0)); // R3
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = GPIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_i,
    input  sense_cfg_t   cfg,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] ack_bits,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] evt;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign evt[i] = pin_event(sync_i[i], prev_q[i], cfg.lvl_mode[i],
                                  cfg.any_edge[i], cfg.invert[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= sync_i;
            // a new event takes priority over a same-cycle acknowledge
            pend_q <= (pend_q & ~ack_bits) | (evt & ien);
        end
    end

    assign pend_o = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (($past(pend_q & ~ack_bits) & ~pend_q) == '0)); // R5
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (($past(evt & ien) & ~pend_q) == '0)); // R7
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pin_in,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_oe,
    output logic              irq_o
);
    logic [GPIO_W-1:0] pin_sync;
    logic [GPIO_W-1:0] pend;
    logic [GPIO_W-1:0] status;
    logic [GPIO_W-1:0] ien_q;
    logic [GPIO_W-1:0] mask_q;
    logic [GPIO_W-1:0] ack_bits;
    sense_cfg_t        cfg_q;

    gpio_sync #(.W(GPIO_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(pin_in), .sync_o(pin_sync)
    );

    gpio_regs #(.W(GPIO_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .pin_sync(pin_sync),
        .status(status), .out_q(pin_out), .dir_q(pin_oe), .ien_q(ien_q),
        .mask_q(mask_q), .cfg_q(cfg_q), .ack_bits(ack_bits)
    );

    gpio_irq_detect #(.W(GPIO_W)) u_det (
        .clk(clk), .rst(rst), .sync_i(pin_sync), .cfg(cfg_q), .ien(ien_q),
        .ack_bits(ack_bits), .pend_o(pend)
    );

    assign status = pend & ien_q;
    assign irq_o  = |(status & ~mask_q);

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst) (&mask_q) |-> !irq_o); // R9
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) irq_o |-> (|ien_q)); // R8
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    import gpio_irq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    logic [31:0] m_out = '0, m_dir = '0, m_pon = '0, m_psel = '0;
    logic [31:0] m_ien = '0, m_mask = '0, m_lm = '0, m_any = '0, m_inv = '0;
    logic [31:0] m_pend = '0, pins = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    function automatic logic [31:0] f_evt(input logic [31:0] o, input logic [31:0] n);
        logic [31:0] rise, fall, lv, ed;
        rise = ~o & n;
        fall = o & ~n;
        lv = m_lm & ((o ^ m_inv) | (n ^ m_inv));
        ed = ~m_lm & ((m_any & (rise | fall)) | (~m_any & ~m_inv & rise) | (~m_any & m_inv & fall));
        return lv | ed;
    endfunction

    function automatic logic [31:0] f_status();
        return m_pend & m_ien;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        case (a)
            OFS_OUT:   m_out = d;
            OFS_SET:   m_out = m_out | d;
            OFS_CLR:   m_out = m_out & ~d;
            OFS_DIR:   m_dir = d;
            OFS_PON:   m_pon = d;
            OFS_PSEL:  m_psel = d;
            OFS_IEN:   m_ien = d;
            OFS_MASK:  m_mask = d;
            OFS_LMODE: m_lm = d;
            OFS_ANYE:  m_any = d;
            OFS_INV:   m_inv = d;
            OFS_ICLR:  m_pend = m_pend & ~d;
            default: ;
        endcase
        @(negedge clk);
        m_pend = m_pend | (m_ien & m_lm & (pins ^ m_inv));
    endtask

    task automatic settle(input logic [31:0] n);
        logic [31:0] o;
        o = pins;
        pin_in = n;
        pins = n;
        repeat (4) @(negedge clk);
        m_pend = m_pend | (f_evt(o, n) & m_ien);
    endtask

    task automatic check_irq(input string tag);
        logic [31:0] d;
        rd(OFS_STAT, d);
        chk({tag, " status"}, d, f_status());
        chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, |(f_status() & ~m_mask)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired got=hang exp=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0] ofs [14];
        ofs = '{OFS_OUT, OFS_IN, OFS_DIR, OFS_SET, OFS_CLR, OFS_PON, OFS_PSEL,
                OFS_IEN, OFS_STAT, OFS_MASK, OFS_ICLR, OFS_LMODE, OFS_ANYE, OFS_INV};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < 14; k++) begin
            rd(ofs[k], d);
            chk("R1 reset read", d, 32'h0);
        end
        chk("R2 reset oe", pin_oe, 32'h0);
        chk("R9 reset irq", {31'd0, irq_o}, 32'h0);

        // R1 / R3 output word and atomic set/clear
        wreg(OFS_OUT, 32'hA5A5_0000);
        rd(OFS_OUT, d);
        chk("R1 out readback", d, 32'hA5A5_0000);
        wreg(OFS_SET, 32'h0000_00FF);
        chk("R3 set", pin_out, 32'hA5A5_00FF);
        wreg(OFS_CLR, 32'hA000_0001);
        chk("R3 clear", pin_out, 32'h05A5_00FE);
        rd(OFS_SET, d);
        chk("R1 set reads zero", d, 32'h0);

        // R2 direction
        wreg(OFS_DIR, 32'hF0F0_1234);
        chk("R2 oe", pin_oe, 32'hF0F0_1234);

        // R10 pull storage only
        wreg(OFS_PON, 32'h0000_1357);
        wreg(OFS_PSEL, 32'h0000_2468);
        rd(OFS_PON, d);
        chk("R10 pull-on readback", d, 32'h0000_1357);
        rd(OFS_PSEL, d);
        chk("R10 pull-select readback", d, 32'h0000_2468);
        chk("R10 out untouched", pin_out, 32'h05A5_00FE);
        chk("R10 oe untouched", pin_oe, 32'hF0F0_1234);

        // R4 input sampling latency
        pin_in = 32'h8000_0001;
        @(negedge clk);
        rd(OFS_IN, d);
        chk("R4 input after one edge", d, 32'h0);
        @(negedge clk);
        rd(OFS_IN, d);
        chk("R4 input after two edges", d, 32'h8000_0001);
        pins = 32'h8000_0001;
        repeat (2) @(negedge clk);

        // R5 edge senses: pin0 rising, pin1 falling, pin2 any edge
        wreg(OFS_INV, 32'h0000_0002);
        wreg(OFS_ANYE, 32'h0000_0004);
        wreg(OFS_IEN, 32'h0000_0007);
        settle(32'h8000_0007);
        rd(OFS_STAT, d);
        chk("R5 any-edge rise only", d, 32'h0000_0004);
        settle(32'h8000_0000);
        rd(OFS_STAT, d);
        chk("R5 falling latched", d, 32'h0000_0006);
        settle(32'h8000_0001);
        rd(OFS_STAT, d);
        chk("R5 rising latched", d, 32'h0000_0007);
        wreg(OFS_ICLR, 32'h0000_0003);
        rd(OFS_STAT, d);
        chk("R7 partial clear", d, 32'h0000_0004);
        wreg(OFS_ICLR, 32'hFFFF_FFFF);
        rd(OFS_STAT, d);
        chk("R7 clear all", d, 32'h0);

        // R9 mask
        wreg(OFS_MASK, 32'h0000_0001);
        settle(32'h8000_0000);
        settle(32'h8000_0001);
        rd(OFS_STAT, d);
        chk("R9 masked status", d, 32'h0000_0001);
        chk("R9 masked irq low", {31'd0, irq_o}, 32'h0);
        wreg(OFS_MASK, 32'h0);
        chk("R9 unmasked irq high", {31'd0, irq_o}, 32'h1);
        wreg(OFS_ICLR, 32'h0000_0001);
        chk("R9 irq low after clear", {31'd0, irq_o}, 32'h0);

        // R6 level senses: pin8 active high, pin9 active low
        wreg(OFS_IEN, 32'h0000_0307);
        wreg(OFS_LMODE, 32'h0000_0300);
        wreg(OFS_INV, 32'h0000_0202);
        rd(OFS_STAT, d);
        chk("R6 active low pending", d, 32'h0000_0200);
        wreg(OFS_ICLR, 32'h0000_0200);
        rd(OFS_STAT, d);
        chk("R6 level reasserts", d, 32'h0000_0200);
        settle(32'h8000_0301);
        rd(OFS_STAT, d);
        chk("R6 active high pending", d, 32'h0000_0300);
        wreg(OFS_ICLR, 32'h0000_0300);
        rd(OFS_STAT, d);
        chk("R6 inactive level clears", d, 32'h0000_0100);

        // R8 enable gating
        wreg(OFS_IEN, 32'h0);
        rd(OFS_STAT, d);
        chk("R8 status hidden", d, 32'h0);
        chk("R8 irq low", {31'd0, irq_o}, 32'h0);
        settle(32'h8000_0300);
        settle(32'h8000_0301);
        wreg(OFS_IEN, 32'h0000_0001);
        rd(OFS_STAT, d);
        chk("R8 disabled pin latched nothing", d, 32'h0);
        check_irq("R8 model");

        // R7 acknowledge in the same cycle as a new edge on pin5
        wreg(OFS_IEN, 32'h0000_0021);
        pin_in = pins | 32'h20;
        repeat (2) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = OFS_ICLR; bus_wdata = 32'h20;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        pins = pins | 32'h20;
        m_pend = m_pend | 32'h20;
        @(negedge clk);
        rd(OFS_STAT, d);
        chk("R7 event wins over clear", d & 32'h20, 32'h20);
        check_irq("R7 model");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [31:0] r;
            op = int'($urandom % 8);
            r = $urandom;
            case (op)
                0, 1, 2: settle(pins ^ (r & $urandom));
                3: wreg(OFS_ICLR, r & $urandom);
                4: wreg(OFS_IEN, r);
                5: wreg(OFS_MASK, r & $urandom);
                6: begin
                    case ($urandom % 3)
                        0: wreg(OFS_LMODE, r);
                        1: wreg(OFS_ANYE, r);
                        default: wreg(OFS_INV, r);
                    endcase
                end
                default: begin
                    case ($urandom % 4)
                        0: wreg(OFS_OUT, r);
                        1: wreg(OFS_SET, r);
                        2: wreg(OFS_CLR, r);
                        default: wreg(OFS_DIR, r);
                    endcase
                end
            endcase
            check_irq("R5 R6 R8 R9 random");
            rd(OFS_IN, d);
            chk("R4 random input", d, pins);
            chk("R3 random out", pin_out, m_out);
            chk("R2 random oe", pin_oe, m_dir);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule